// File: doc/BRIEF.md
# Four-Channel Buffered Pulse-Width Modulator

This block drives four independent pulse-width outputs from a small memory-mapped register bus. Each channel counts prescaled clock ticks from zero up to its period value minus one. It holds its output at the inactive level until the count reaches the channel's duty value, then drives the active level for the rest of the period. The duty value therefore measures the inactive part of the period, and the time spent active is period minus duty. A polarity bit per channel chooses whether the active level is high or low.

Software retunes a running channel through two staging registers, one for duty and one for period. Their contents move into the live registers only when the current period ends, so no period is ever cut short or stretched partway through. Every period end sets that channel's bit in a shared event register, which is cleared by reading it. A mask register selects which event bits raise the interrupt line. Channels are started and stopped through write-one-to-act registers. A stop is held until the current period ends, and a stopped channel rests at its inactive level.

Top module: `pwm_quad`

## Requirements
- R1: After reset every readable register returns 0, all outputs are low and the interrupt line is low.
- R2: A running channel with period P and duty D repeats every P ticks; a period starts inactive, stays inactive while the count is below D and is active for the remaining P-D ticks.
- R3: Bit 9 of the channel mode register (offset 0x00 of the bank) inverts the output; with bit 9 clear the inactive level is low, with it set the inactive level is high, and a stopped channel drives its inactive level.
- R4: Bits [3:0] of the mode register select one counter tick every 2^n input clocks; values above 10 act as 10 and read back as written.
- R5: Values written to the duty staging register (bank offset 0x08) or period staging register (bank offset 0x10) are reflected in the live duty (0x04) and period (0x0C) registers, and in the output, only from the first period boundary after the write; the staging registers read back what was written.
- R6: Writes to the live duty or period register have no effect while the channel runs and take effect at once while it is stopped.
- R7: Writing 1 to bit n of the start register (0x04) starts a stopped channel n with its count at 0; the run status register (0x0C) shows bit n set while channel n runs, 0x0F with all four running.
- R8: Writing 1 to bit n of the stop register (0x08) stops channel n at the end of its current period; bit n of the run status stays set until then.
- R9: Bit n of the event register (0x1C) sets at each period end of channel n and all bits clear when the register is read; a period end in the same cycle as the read leaves that bit set.
- R10: The interrupt line is high exactly when some event bit is set and the matching bit of the mask register (0x10, reset 0) is set.
- R11: A duty value at or above the period keeps the output inactive for the whole period; a duty value of 0 keeps it active for the whole period.

Channel n's bank starts at byte address 0x200 + n*0x20.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_re | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_rdata | output | 32 | Read data, zero when no read is strobed |
| pwm_out | output | 4 | One pulse-width output per channel |
| irq | output | 1 | Interrupt, OR of masked event bits |

## Verification
A read of the event register and a channel's period end can land on the same clock edge. One would clear the bit and the other would set it. The bench starts a channel with a known period, counts cycles from the start write, and strobes the event read in the cycle just before the period's last edge. That read must return the bit clear, and a second read must find it set. The same cycle counting places staging writes and stop requests mid-period, and the bench judges the output level sample by sample on both sides of the boundary.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
  // Default geometry
  localparam int NCH_DEF     = 4;
  localparam int CNT_W_DEF   = 16;
  localparam int ADDR_W_DEF  = 12;
  localparam int DATA_W_DEF  = 32;
  localparam int DIV_SEL_W   = 4;
  localparam int DIV_SEL_MAX = 10;

  // Global register offsets
  localparam int G_START  = 'h04;
  localparam int G_STOP   = 'h08;
  localparam int G_RUN    = 'h0C;
  localparam int G_MASK   = 'h10;
  localparam int G_EVENT  = 'h1C;

  // Channel banks
  localparam int BANK_BASE  = 'h200;
  localparam int BANK_SHIFT = 5;

  // Offsets inside a channel bank
  localparam logic [BANK_SHIFT-1:0] C_MODE    = 5'h00;
  localparam logic [BANK_SHIFT-1:0] C_DUTY    = 5'h04;
  localparam logic [BANK_SHIFT-1:0] C_DUTY_ST = 5'h08;
  localparam logic [BANK_SHIFT-1:0] C_PER     = 5'h0C;
  localparam logic [BANK_SHIFT-1:0] C_PER_ST  = 5'h10;

  // Mode register field positions
  localparam int MODE_POL_BIT = 9;
endpackage

// File: rtl/pwm_quad_rstsync.sv
module pwm_quad_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/pwm_quad_presc.sv
module pwm_quad_presc #(
  parameter int SEL_W   = 4,
  parameter int SEL_MAX = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [SEL_MAX-1:0] div_q, div_d;
  logic [SEL_W-1:0]   sel_eff;
  logic [SEL_MAX:0]   limit;

  always_comb begin
    sel_eff = (int'(sel) > SEL_MAX) ? SEL_W'(SEL_MAX) : sel;
    limit   = ({{SEL_MAX{1'b0}}, 1'b1} << sel_eff) - {{SEL_MAX{1'b0}}, 1'b1};
    tick    = ({1'b0, div_q} == limit);
    if (clr || tick) div_d = '0;
    else             div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan #(
  parameter int CNT_W   = 16,
  parameter int SEL_W   = 4,
  parameter int SEL_MAX = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] wval,
  input  logic             wr_mode,
  input  logic [SEL_W-1:0] wsel,
  input  logic             wpol,
  input  logic             wr_duty,
  input  logic             wr_duty_st,
  input  logic             wr_per,
  input  logic             wr_per_st,
  input  logic             start,
  input  logic             stop,
  output logic             run,
  output logic             bnd,
  output logic             pwm,
  output logic [SEL_W-1:0] sel_q,
  output logic             pol_q,
  output logic [CNT_W-1:0] duty_q,
  output logic [CNT_W-1:0] per_q,
  output logic [CNT_W-1:0] duty_st_q,
  output logic [CNT_W-1:0] per_st_q
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] duty_d, per_d, duty_st_d, per_st_d;
  logic [SEL_W-1:0] sel_d;
  logic             pol_d;
  logic             run_q, run_d;
  logic             stop_pend_q, stop_pend_d;
  logic             duty_pend_q, duty_pend_d;
  logic             per_pend_q, per_pend_d;
  logic             go;
  logic             tick;
  logic             last;

  assign go = start & ~run_q;

  pwm_quad_presc #(.SEL_W(SEL_W), .SEL_MAX(SEL_MAX)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (~run_q | go),
    .sel  (sel_q),
    .tick (tick)
  );

  // Period ends when the next count would reach the period value.
  assign last = ({1'b0, cnt_q} + 1'b1) >= {1'b0, per_q};
  assign bnd  = run_q & tick & last;

  always_comb begin
    // counter
    if (go || bnd)         cnt_d = '0;
    else if (run_q && tick) cnt_d = cnt_q + 1'b1;
    else                   cnt_d = cnt_q;

    // run / stop request
    if (go)                      run_d = 1'b1;
    else if (bnd && stop_pend_q) run_d = 1'b0;
    else                         run_d = run_q;

    if (start)             stop_pend_d = 1'b0;
    else if (stop && run_q) stop_pend_d = 1'b1;
    else if (bnd)          stop_pend_d = 1'b0;
    else                   stop_pend_d = stop_pend_q;

    // mode
    sel_d = wr_mode ? wsel : sel_q;
    pol_d = wr_mode ? wpol : pol_q;

    // staging registers
    duty_st_d = wr_duty_st ? wval : duty_st_q;
    per_st_d  = wr_per_st  ? wval : per_st_q;

    if (wr_duty_st) duty_pend_d = 1'b1;
    else if (bnd)   duty_pend_d = 1'b0;
    else            duty_pend_d = duty_pend_q;

    if (wr_per_st)  per_pend_d = 1'b1;
    else if (bnd)   per_pend_d = 1'b0;
    else            per_pend_d = per_pend_q;

    // live registers
    if (wr_duty && !run_q)     duty_d = wval;
    else if (bnd && duty_pend_q) duty_d = duty_st_q;
    else                       duty_d = duty_q;

    if (wr_per && !run_q)      per_d = wval;
    else if (bnd && per_pend_q) per_d = per_st_q;
    else                       per_d = per_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      run_q       <= 1'b0;
      stop_pend_q <= 1'b0;
      sel_q       <= '0;
      pol_q       <= 1'b0;
      duty_q      <= '0;
      per_q       <= '0;
      duty_st_q   <= '0;
      per_st_q    <= '0;
      duty_pend_q <= 1'b0;
      per_pend_q  <= 1'b0;
    end else begin
      cnt_q       <= cnt_d;
      run_q       <= run_d;
      stop_pend_q <= stop_pend_d;
      sel_q       <= sel_d;
      pol_q       <= pol_d;
      duty_q      <= duty_d;
      per_q       <= per_d;
      duty_st_q   <= duty_st_d;
      per_st_q    <= per_st_d;
      duty_pend_q <= duty_pend_d;
      per_pend_q  <= per_pend_d;
    end
  end

  assign run = run_q;
  assign pwm = pol_q ^ (run_q & (cnt_q >= duty_q));
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter int NCH    = NCH_DEF,
  parameter int CNT_W  = CNT_W_DEF,
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int DATA_W = DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_out,
  output logic              irq
);
  localparam int BANK_ID_W = ADDR_W - BANK_SHIFT;
  localparam int STRIDE    = 1 << BANK_SHIFT;

  logic rst_n_s;

  pwm_quad_rstsync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_s)
  );

  logic [BANK_SHIFT-1:0] ofs;
  logic [NCH-1:0]        bank_hit;
  logic [NCH-1:0]        start_vec, stop_vec;
  logic [NCH-1:0]        ch_run, ch_bnd, ch_pol;
  logic [DIV_SEL_W-1:0]  ch_sel     [NCH];
  logic [CNT_W-1:0]      ch_duty    [NCH];
  logic [CNT_W-1:0]      ch_per     [NCH];
  logic [CNT_W-1:0]      ch_duty_st [NCH];
  logic [CNT_W-1:0]      ch_per_st  [NCH];
  logic [NCH-1:0]        evt_q, evt_d;
  logic [NCH-1:0]        mask_q, mask_d;
  logic                  hit_start, hit_stop, hit_run, hit_mask, hit_evt;
  logic                  unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:CNT_W];
  assign ofs          = bus_addr[BANK_SHIFT-1:0];

  assign hit_start = (bus_addr == ADDR_W'(G_START));
  assign hit_stop  = (bus_addr == ADDR_W'(G_STOP));
  assign hit_run   = (bus_addr == ADDR_W'(G_RUN));
  assign hit_mask  = (bus_addr == ADDR_W'(G_MASK));
  assign hit_evt   = (bus_addr == ADDR_W'(G_EVENT));

  assign start_vec = (bus_we && hit_start) ? bus_wdata[NCH-1:0] : '0;
  assign stop_vec  = (bus_we && hit_stop)  ? bus_wdata[NCH-1:0] : '0;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int BANK_I = BANK_BASE / STRIDE + g;
    assign bank_hit[g] = (bus_addr[ADDR_W-1:BANK_SHIFT] == BANK_ID_W'(BANK_I));

    pwm_quad_chan #(
      .CNT_W  (CNT_W),
      .SEL_W  (DIV_SEL_W),
      .SEL_MAX(DIV_SEL_MAX)
    ) u_chan (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .wval      (bus_wdata[CNT_W-1:0]),
      .wr_mode   (bus_we & bank_hit[g] & (ofs == C_MODE)),
      .wsel      (bus_wdata[DIV_SEL_W-1:0]),
      .wpol      (bus_wdata[MODE_POL_BIT]),
      .wr_duty   (bus_we & bank_hit[g] & (ofs == C_DUTY)),
      .wr_duty_st(bus_we & bank_hit[g] & (ofs == C_DUTY_ST)),
      .wr_per    (bus_we & bank_hit[g] & (ofs == C_PER)),
      .wr_per_st (bus_we & bank_hit[g] & (ofs == C_PER_ST)),
      .start     (start_vec[g]),
      .stop      (stop_vec[g]),
      .run       (ch_run[g]),
      .bnd       (ch_bnd[g]),
      .pwm       (pwm_out[g]),
      .sel_q     (ch_sel[g]),
      .pol_q     (ch_pol[g]),
      .duty_q    (ch_duty[g]),
      .per_q     (ch_per[g]),
      .duty_st_q (ch_duty_st[g]),
      .per_st_q  (ch_per_st[g])
    );
  end

  // Event and mask registers: a period end wins over a same-cycle read clear.
  always_comb begin
    evt_d  = ((bus_re && hit_evt) ? '0 : evt_q) | ch_bnd;
    mask_d = (bus_we && hit_mask) ? bus_wdata[NCH-1:0] : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      evt_q  <= '0;
      mask_q <= '0;
    end else begin
      evt_q  <= evt_d;
      mask_q <= mask_d;
    end
  end

  assign irq = |(evt_q & mask_q);

  // Read path
  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      if (hit_run)  bus_rdata[NCH-1:0] = ch_run;
      if (hit_mask) bus_rdata[NCH-1:0] = mask_q;
      if (hit_evt)  bus_rdata[NCH-1:0] = evt_q;
      for (int i = 0; i < NCH; i++) begin
        if (bank_hit[i]) begin
          case (ofs)
            C_MODE: begin
              bus_rdata[DIV_SEL_W-1:0]  = ch_sel[i];
              bus_rdata[MODE_POL_BIT]   = ch_pol[i];
            end
            C_DUTY:    bus_rdata[CNT_W-1:0] = ch_duty[i];
            C_DUTY_ST: bus_rdata[CNT_W-1:0] = ch_duty_st[i];
            C_PER:     bus_rdata[CNT_W-1:0] = ch_per[i];
            C_PER_ST:  bus_rdata[CNT_W-1:0] = ch_per_st[i];
            default:   bus_rdata = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/pwm_quad_sva.sv
module pwm_quad_sva #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] run,
  input logic [NCH-1:0] bnd,
  input logic [NCH-1:0] evt,
  input logic [NCH-1:0] mask,
  input logic [NCH-1:0] pol,
  input logic [NCH-1:0] pwm_out,
  input logic           irq
);
  // R9: every period end leaves its event bit set on the next cycle
  a_r9_event_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd != '0) |=> ((evt & $past(bnd)) == $past(bnd)));

  // R9: an event bit only rises after a period end
  a_r9_event_needs_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & ~$past(evt) & ~$past(bnd)) == '0));

  // R8: a channel stops only at a period end
  a_r8_stop_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    ((~run & $past(run) & ~$past(bnd)) == '0));

  // R3: stopped channels rest at their inactive level
  a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    ((~run & (pwm_out ^ pol)) == '0));

  // R10: interrupt only with an unmasked event
  a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((evt & mask) != '0));

  // R10: an unmasked event always raises the interrupt
  a_r10_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & mask) != '0) |-> irq);
endmodule

bind pwm_quad pwm_quad_sva #(.NCH(NCH)) u_sva (
  .clk    (clk),
  .rst_n  (rst_n),
  .run    (ch_run),
  .bnd    (ch_bnd),
  .evt    (evt_q),
  .mask   (mask_q),
  .pol    (ch_pol),
  .pwm_out(pwm_out),
  .irq    (irq)
);

// File: tb/tb_pwm_quad.sv
module tb_pwm_quad;
  localparam logic [11:0] A_START = 12'h004;
  localparam logic [11:0] A_STOP  = 12'h008;
  localparam logic [11:0] A_RUN   = 12'h00C;
  localparam logic [11:0] A_MASK  = 12'h010;
  localparam logic [11:0] A_EVT   = 12'h01C;

  logic        clk;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we;
  logic        bus_re;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;
  logic        irq;

  int  checks;
  int  failures;
  bit  done;

  pwm_quad dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_we   (bus_we),
    .bus_re   (bus_re),
    .bus_rdata(bus_rdata),
    .pwm_out  (pwm_out),
    .irq      (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [11:0] cha(input int ch, input int ofs);
    return 12'(12'h200 + ch * 32 + ofs);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge.
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic skip(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic meas(input int ch, input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_out[ch]) highs++;
      @(negedge clk);
    end
  endtask

  task automatic cfg(input int ch, input int sel, input bit pol, input int per, input int duty);
    wr(cha(ch, 'h00), (32'(pol) << 9) | 32'(sel));
    wr(cha(ch, 'h0C), 32'(per));
    wr(cha(ch, 'h04), 32'(duty));
  endtask

  task automatic stop_all();
    logic [31:0] v;
    bit stopped;
    stopped = 1'b0;
    wr(A_STOP, 32'hF);
    for (int i = 0; i < 5000 && !stopped; i++) begin
      rd(A_RUN, v);
      if (v[3:0] == 4'h0) stopped = 1'b1;
    end
    chk("R8 all channels stop", 32'(stopped), 32'd1);
    rd(A_EVT, v);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_RUN, v);  chk("R1 run status reset", v, 0);
    rd(A_EVT, v);  chk("R1 event reset", v, 0);
    rd(A_MASK, v); chk("R1 mask reset", v, 0);
    rd(cha(2, 'h00), v); chk("R1 mode reset", v, 0);
    rd(cha(3, 'h0C), v); chk("R1 period reset", v, 0);
    chk("R1 outputs low", 32'(pwm_out), 0);
    chk("R1 irq low", 32'(irq), 0);
  endtask

  task automatic t_basic();
    int h;
    logic [31:0] v;
    cfg(0, 0, 1'b0, 10, 3);
    wr(A_START, 32'h1);
    chk("R2 period opens inactive", 32'(pwm_out[0]), 0);
    meas(0, 10, h);
    chk("R2 active ticks = P-D", 32'(h), 7);
    rd(A_RUN, v);
    chk("R7 run status bit", v, 32'h1);
    stop_all();
  endtask

  task automatic t_polarity();
    int h;
    logic [31:0] v;
    cfg(1, 0, 1'b1, 8, 2);
    chk("R3 inverted idle high", 32'(pwm_out[1]), 1);
    rd(cha(1, 'h00), v);
    chk("R3 mode readback", v, 32'h200);
    wr(A_START, 32'h2);
    meas(1, 8, h);
    chk("R3 inverted high ticks = D", 32'(h), 2);
    stop_all();
    chk("R3 stopped inverted idle high", 32'(pwm_out[1]), 1);
  endtask

  task automatic t_prescale();
    int h;
    cfg(2, 2, 1'b0, 4, 1);
    wr(A_START, 32'h4);
    meas(2, 16, h);
    chk("R4 divide-by-4 active clocks", 32'(h), 12);
    chk("R4 next period opens inactive", 32'(pwm_out[2]), 0);
    stop_all();
  endtask

  task automatic t_clamp();
    logic [31:0] v;
    cfg(3, 15, 1'b0, 2, 1);
    rd(cha(3, 'h00), v);
    chk("R4 selector reads as written", v, 32'hF);
    wr(A_START, 32'h8);
    skip(1023);
    chk("R4 clamp: still first tick", 32'(pwm_out[3]), 0);
    skip(1);
    chk("R4 clamp: second tick after 1024", 32'(pwm_out[3]), 1);
    stop_all();
  endtask

  task automatic t_buffered();
    int h;
    logic [31:0] v;
    cfg(0, 0, 1'b0, 10, 3);
    wr(A_START, 32'h1);           // idx0
    wr(cha(0, 'h08), 32'd4);      // idx1
    wr(cha(0, 'h10), 32'd6);      // idx2
    rd(cha(0, 'h04), v);          // idx3
    chk("R5 live duty unchanged mid-period", v, 32'd3);
    meas(0, 7, h);                // idx3..9
    chk("R5 current period keeps old duty", 32'(h), 7);
    meas(0, 6, h);                // idx10..15
    chk("R5 next period uses new duty", 32'(h), 2);
    chk("R5 new period length", 32'(pwm_out[0]), 0);
    rd(cha(0, 'h04), v); chk("R5 live duty after boundary", v, 32'd4);
    rd(cha(0, 'h0C), v); chk("R5 live period after boundary", v, 32'd6);
    rd(cha(0, 'h10), v); chk("R5 period staging readback", v, 32'd6);
    wr(cha(0, 'h04), 32'd0);
    rd(cha(0, 'h04), v);
    chk("R6 live write ignored while running", v, 32'd4);
    stop_all();
    wr(cha(0, 'h04), 32'd1);
    rd(cha(0, 'h04), v);
    chk("R6 live write applies while stopped", v, 32'd1);
  endtask

  task automatic t_extremes();
    int h;
    cfg(0, 0, 1'b0, 5, 7);
    wr(A_START, 32'h1);
    meas(0, 5, h);
    chk("R11 duty above period stays inactive", 32'(h), 0);
    stop_all();
    cfg(0, 0, 1'b0, 5, 0);
    wr(A_START, 32'h1);
    meas(0, 5, h);
    chk("R11 zero duty stays active", 32'(h), 5);
    stop_all();
  endtask

  task automatic t_disable();
    int h;
    logic [31:0] v;
    cfg(0, 0, 1'b0, 10, 0);
    wr(A_START, 32'h1);           // idx0
    wr(A_STOP, 32'h1);            // idx1
    rd(A_RUN, v);                 // idx2
    chk("R8 run bit held after stop request", v, 32'h1);
    meas(0, 8, h);                // idx2..9
    chk("R8 output runs to period end", 32'(h), 8);
    chk("R8 inactive after boundary", 32'(pwm_out[0]), 0);
    rd(A_RUN, v);
    chk("R8 run bit clear after boundary", v, 32'h0);
    stop_all();
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(A_MASK, 32'h0);
    cfg(1, 0, 1'b0, 4, 1);
    wr(A_START, 32'h2);           // idx0
    skip(6);                      // idx6
    chk("R10 masked event keeps irq low", 32'(irq), 0);
    wr(A_MASK, 32'h2);            // idx7
    chk("R10 unmasked event raises irq", 32'(irq), 1);
    skip(2);                      // idx9
    rd(A_EVT, v);                 // idx10
    chk("R9 event bit reported", v, 32'h2);
    chk("R9 read clears event, R10 irq drops", 32'(irq), 0);
    stop_all();
    wr(A_MASK, 32'h0);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    cfg(0, 0, 1'b0, 10, 5);
    wr(A_START, 32'h1);           // idx0
    skip(9);                      // idx9
    rd(A_EVT, v);                 // read clear at the boundary edge
    chk("R9 event not yet set before boundary", v, 32'h0);
    rd(A_EVT, v);
    chk("R9 period end wins over read clear", v, 32'h1);
    stop_all();
  endtask

  task automatic t_allon();
    logic [31:0] v;
    for (int c = 0; c < 4; c++) cfg(c, 0, 1'b0, 4, 2);
    wr(A_START, 32'hF);
    rd(A_RUN, v);
    chk("R7 all channels running", v, 32'hF);
    stop_all();
    rd(A_RUN, v);
    chk("R7 run status clear after stop", v, 32'h0);
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0;
    rst_n = 1'b0;
    skip(3);
    rst_n = 1'b1;
    skip(4);
    t_reset();
    t_basic();
    t_polarity();
    t_prescale();
    t_clamp();
    t_buffered();
    t_extremes();
    t_disable();
    t_irq();
    t_collision();
    t_allon();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R1-scope run actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule